// File: doc/BRIEF.md
# Maskable Interrupt Router with Configurable Output Pads

This block collects four interrupt sources (periodic tick, alarm match, timer expiry and supply loss) into a pending-status register. A host enables or disables each source through a mask register. The block then drives two output pins.

The first pin is a dedicated interrupt line. The second is a shared pin that either carries a second interrupt line or passes through the oscillator clock or the timer-0 output. Each interrupt line has its own routing field, so it can answer any subset of the sources. Each pin also has its own polarity and drive-type settings. While the system runs on battery, both pins are forced to open-drain drive.

Source events are single-cycle pulses. A pending bit stays set, and the interrupt level stays asserted, until the host writes a 1 to that bit. The host writes registers through a plain write-enable, address and data port. Status and mask are visible as output ports. The pad itself sits outside the block: each pin is modelled as a level plus a drive enable, and the drive enable is low when the pin is released to its pull-up.

Top module: `irq_router`

## Requirements
- R1: After reset, status and mask read 0, and every routing and configuration field is 0. This means both pins are active low and open drain, the shared pin is in interrupt mode, and both drive enables are 0.
- R2: A one-cycle pulse on `src_evt[i]` sets `status_o[i]` at that clock edge. Bit 0 is periodic, bit 1 is alarm, bit 2 is timer and bit 3 is supply loss.
- R3: A write to address 0 clears every status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R4: If a source pulse and a clearing write hit the same status bit in the same cycle, the bit ends set.
- R5: A status bit holds its value while neither a pulse nor a clearing write touches it. Writing the mask register never changes status.
- R6: Address 1 is the mask, where bit i = 1 enables source i. Address 2 holds the routing: bits [3:0] select the sources for the dedicated line and bits [7:4] select them for the shared line. A line is asserted when the OR of status & mask & route is 1.
- R7: In the address 3 configuration register, bit 0 = 1 makes the dedicated pin active high and bit 2 = 1 does the same for the shared pin. The pin level is the selected signal when the pin is active high and its inverse otherwise.
- R8: Configuration bit 1 (dedicated pin) and bit 3 (shared pin) select push-pull drive, where the drive enable is always 1. With the bit at 0 the pin is open drain, and the drive enable is 1 only while the pin level is 0.
- R9: While `on_battery` is 1, both pins behave as open drain whatever bits 1 and 3 hold.
- R10: Configuration bits [5:4] select the shared pin's signal: 01 is `osc_clk`, 10 is `tmr0_out`, and 00 or 11 is the shared interrupt line. The polarity bit applies to the selected signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_evt | input | 4 | One-cycle source event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| on_battery | input | 1 | System running from battery |
| osc_clk | input | 1 | Buffered oscillator clock for the shared pin |
| tmr0_out | input | 1 | Timer-0 output for the shared pin |
| status_o | output | 4 | Pending status bits |
| mask_o | output | 4 | Source enable bits |
| irq_lvl | output | 1 | Dedicated pin level when driven |
| irq_oe | output | 1 | Dedicated pin drive enable |
| mfo_lvl | output | 1 | Shared pin level when driven |
| mfo_oe | output | 1 | Shared pin drive enable |

## Verification
The bench aims at the cycle where a pulse and a clearing write hit the same bit. A design that let the clear win would drop an interrupt that has just arrived. It writes zeros to status and rewrites the mask while bits are pending; a wrong design would lose pending events that were never serviced. It toggles `on_battery` while pins are configured push-pull. A design that ignored that input would drive the pin high on battery. It walks the shared-pin selector through all four codes with both polarities. An inverted or misdecoded selector would put the wrong signal on the pin. A reference model compares every output on every cycle under random traffic.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_MASK   = 1;
  localparam int ADDR_ROUTE  = 2;
  localparam int ADDR_CFG    = 3;

  typedef enum logic [1:0] {
    MFO_IRQ  = 2'b00,
    MFO_OSC  = 2'b01,
    MFO_TMR  = 2'b10,
    MFO_IRQX = 2'b11
  } mfo_sel_e;

  typedef struct packed {
    logic     act_high;
    logic     push_pull;
  } pad_cfg_t;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               clr_we,
  input  logic [NUM_SRC-1:0] clr_bits,
  output logic [NUM_SRC-1:0] status
);
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] status_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_comb begin
      status_d[i] = evt[i] | (status_q[i] & ~(clr_we & clr_bits[i]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[i] <= 1'b0;
      else        status_q[i] <= status_d[i];
    end
  end

  assign status = status_q;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NUM_SRC-1:0] mask,
  output logic [NUM_SRC-1:0] route_a,
  output logic [NUM_SRC-1:0] route_b,
  output pad_cfg_t           pad_a,
  output pad_cfg_t           pad_b,
  output mfo_sel_e           mfo_sel
);
  localparam int CFG_W = 6;

  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic [NUM_SRC-1:0] ra_q, ra_d, rb_q, rb_d;
  logic [CFG_W-1:0]   cfg_q, cfg_d;
  logic               mask_en, route_en, cfg_en;

  always_comb begin
    mask_en  = wr_en && (wr_addr == ADDR_W'(ADDR_MASK));
    route_en = wr_en && (wr_addr == ADDR_W'(ADDR_ROUTE));
    cfg_en   = wr_en && (wr_addr == ADDR_W'(ADDR_CFG));
    mask_d   = mask_q;
    ra_d     = ra_q;
    rb_d     = rb_q;
    cfg_d    = cfg_q;
    if (mask_en)  mask_d = wr_data[NUM_SRC-1:0];
    if (route_en) begin
      ra_d = wr_data[NUM_SRC-1:0];
      rb_d = wr_data[2*NUM_SRC-1:NUM_SRC];
    end
    if (cfg_en)   cfg_d = wr_data[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ra_q   <= '0;
      rb_q   <= '0;
      cfg_q  <= '0;
    end else begin
      mask_q <= mask_d;
      ra_q   <= ra_d;
      rb_q   <= rb_d;
      cfg_q  <= cfg_d;
    end
  end

  assign mask            = mask_q;
  assign route_a         = ra_q;
  assign route_b         = rb_q;
  assign pad_a.act_high  = cfg_q[0];
  assign pad_a.push_pull = cfg_q[1];
  assign pad_b.act_high  = cfg_q[2];
  assign pad_b.push_pull = cfg_q[3];
  assign mfo_sel         = mfo_sel_e'(cfg_q[5:4]);
endmodule

// File: rtl/irq_pad_drv.sv
module irq_pad_drv
  import irq_pkg::*;
(
  input  logic     sig,
  input  pad_cfg_t cfg,
  input  logic     force_od,
  output logic     lvl,
  output logic     oe
);
  logic pp_eff;

  always_comb begin
    lvl    = cfg.act_high ? sig : ~sig;
    pp_eff = cfg.push_pull & ~force_od;
    oe     = pp_eff | ~lvl;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               on_battery,
  input  logic               osc_clk,
  input  logic               tmr0_out,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               irq_lvl,
  output logic               irq_oe,
  output logic               mfo_lvl,
  output logic               mfo_oe
);
  localparam int NUM_PIN  = 2;
  localparam int SYNC_LEN = 2;

  logic [SYNC_LEN-1:0] rst_sync_q;
  logic                rst_sync_n;
  logic [NUM_SRC-1:0]  status_q, mask_q, route_a, route_b;
  pad_cfg_t            pad_a, pad_b;
  mfo_sel_e            mfo_sel;
  logic                line_a, line_b, mfo_sig;
  logic                clr_we;
  logic [NUM_PIN-1:0]  pin_sig, pin_lvl, pin_oe;
  pad_cfg_t            pin_cfg [NUM_PIN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[SYNC_LEN-1];

  assign clr_we = wr_en && (wr_addr == ADDR_W'(ADDR_STATUS));

  irq_status_reg #(.NUM_SRC(NUM_SRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt      (src_evt),
    .clr_we   (clr_we),
    .clr_bits (wr_data[NUM_SRC-1:0]),
    .status   (status_q)
  );

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mask    (mask_q),
    .route_a (route_a),
    .route_b (route_b),
    .pad_a   (pad_a),
    .pad_b   (pad_b),
    .mfo_sel (mfo_sel)
  );

  always_comb begin
    line_a = |(status_q & mask_q & route_a);
    line_b = |(status_q & mask_q & route_b);
    unique case (mfo_sel)
      MFO_OSC: mfo_sig = osc_clk;
      MFO_TMR: mfo_sig = tmr0_out;
      default: mfo_sig = line_b;
    endcase
  end

  assign pin_sig    = {mfo_sig, line_a};
  assign pin_cfg[0] = pad_a;
  assign pin_cfg[1] = pad_b;

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pad
    irq_pad_drv u_pad (
      .sig      (pin_sig[p]),
      .cfg      (pin_cfg[p]),
      .force_od (on_battery),
      .lvl      (pin_lvl[p]),
      .oe       (pin_oe[p])
    );
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_lvl  = pin_lvl[0];
  assign irq_oe   = pin_oe[0];
  assign mfo_lvl  = pin_lvl[1];
  assign mfo_oe   = pin_oe[1];
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [NUM_SRC-1:0] src_evt,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               on_battery,
  input logic [NUM_SRC-1:0] status_o,
  input logic [NUM_SRC-1:0] mask_o,
  input logic               irq_lvl,
  input logic               irq_oe,
  input logic               mfo_lvl,
  input logic               mfo_oe,
  input logic               cfg_a_high,
  input logic               cfg_a_pp
);
  logic clr_hit;
  assign clr_hit = wr_en && (wr_addr == '0);

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|src_evt) |=> ((status_o & $past(src_evt)) == $past(src_evt))); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_hit |=> ((status_o & $past(wr_data[NUM_SRC-1:0] & ~src_evt)) == '0)); // R3

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_hit && |(src_evt & wr_data[NUM_SRC-1:0])) |=>
      ((status_o & $past(src_evt)) == $past(src_evt))); // R4

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr_hit && src_evt == '0) |=> (status_o == $past(status_o))); // R5

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((status_o & mask_o) == '0) |-> (irq_lvl == !cfg_a_high)); // R6

  AST_PP_DRIVES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_a_pp && !on_battery) |-> irq_oe); // R8

  AST_BATT_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    on_battery |-> ((!irq_oe || !irq_lvl) && (!mfo_oe || !mfo_lvl))); // R9
endmodule

bind irq_router irq_router_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .src_evt    (src_evt),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .on_battery (on_battery),
  .status_o   (status_o),
  .mask_o     (mask_o),
  .irq_lvl    (irq_lvl),
  .irq_oe     (irq_oe),
  .mfo_lvl    (mfo_lvl),
  .mfo_oe     (mfo_oe),
  .cfg_a_high (pad_a.act_high),
  .cfg_a_pp   (pad_a.push_pull)
);

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_evt = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       on_battery = 1'b0;
  logic       osc_clk = 1'b0;
  logic       tmr0_out = 1'b0;
  logic [3:0] status_o, mask_o;
  logic       irq_lvl, irq_oe, mfo_lvl, mfo_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_router dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .on_battery(on_battery),
    .osc_clk(osc_clk), .tmr0_out(tmr0_out), .status_o(status_o),
    .mask_o(mask_o), .irq_lvl(irq_lvl), .irq_oe(irq_oe),
    .mfo_lvl(mfo_lvl), .mfo_oe(mfo_oe)
  );

  // Behavioural reference state
  int m_status, m_mask, m_route, m_cfg;
  int since_rel = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      since_rel = 0;
      m_status = 0; m_mask = 0; m_route = 0; m_cfg = 0;
    end else begin
      if (since_rel >= 2) begin
        if (wr_en && wr_addr == 2'd0) m_status = m_status & ~int'(wr_data[3:0]);
        m_status = m_status | int'(src_evt);
        if (wr_en && wr_addr == 2'd1) m_mask  = int'(wr_data[3:0]);
        if (wr_en && wr_addr == 2'd2) m_route = int'(wr_data);
        if (wr_en && wr_addr == 2'd3) m_cfg   = int'(wr_data[5:0]);
      end
      since_rel++;
    end
  end

  function automatic bit exp_lvl(input bit pin);
    bit a, hi; int sel;
    sel = (m_cfg >> 4) & 3;
    if (!pin) a = ((m_status & m_mask & m_route & 15) != 0);
    else if (sel == 1) a = osc_clk;
    else if (sel == 2) a = tmr0_out;
    else a = ((m_status & m_mask & (m_route >> 4) & 15) != 0);
    hi = pin ? m_cfg[2] : m_cfg[0];
    return hi ? a : !a;
  endfunction

  function automatic bit exp_oe(input bit pin);
    bit pp;
    pp = (pin ? m_cfg[3] : m_cfg[1]) && !on_battery;
    return pp || !exp_lvl(pin);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && since_rel >= 2 && !done) begin
      chk("R2 status vs model", int'(status_o), m_status);
      chk("R6 mask vs model", int'(mask_o), m_mask);
      chk("R7 irq level vs model", int'(irq_lvl), int'(exp_lvl(1'b0)));
      chk("R8 irq drive vs model", int'(irq_oe), int'(exp_oe(1'b0)));
      chk("R10 mfo level vs model", int'(mfo_lvl), int'(exp_lvl(1'b1)));
      chk("R9 mfo drive vs model", int'(mfo_oe), int'(exp_oe(1'b1)));
    end
  end

  task automatic apply(input logic [3:0] e, input logic we, input logic [1:0] a, input logic [7:0] d);
    src_evt = e; wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    src_evt = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    apply(4'h0, 1'b1, a, d);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 status", int'(status_o), 0);
    chk("R1 mask", int'(mask_o), 0);
    chk("R1 irq_oe", int'(irq_oe), 0);
    chk("R1 mfo_oe", int'(mfo_oe), 0);
    chk("R1 irq_lvl", int'(irq_lvl), 1);

    // R2: pulse sets status, masked line stays quiet
    apply(4'h1, 1'b0, 2'd0, 8'h00);
    chk("R2 periodic sets bit0", int'(status_o), 1);
    chk("R6 masked source no assert", int'(irq_oe), 0);

    // R6 enable and route to dedicated line; R8 open drain active low drives
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h01);
    chk("R6 routed asserts irq_lvl", int'(irq_lvl), 0);
    chk("R8 open-drain drives low", int'(irq_oe), 1);

    // R3: writing zero has no effect, writing one clears
    wr(2'd0, 8'h00);
    chk("R3 zero write keeps", int'(status_o), 1);
    wr(2'd0, 8'h01);
    chk("R3 one write clears", int'(status_o), 0);
    chk("R3 irq released", int'(irq_oe), 0);

    // R4: set and clear same cycle on bit1
    apply(4'h2, 1'b1, 2'd0, 8'h02);
    chk("R4 set wins", int'(status_o), 2);

    // R5: mask write leaves status
    wr(2'd1, 8'h00);
    chk("R5 status kept after mask write", int'(status_o), 2);
    repeat (3) @(negedge clk);
    #1 chk("R5 status holds", int'(status_o), 2);

    // R7/R8 active high push-pull on dedicated pin
    wr(2'd1, 8'h0F);
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h03);
    chk("R7 active high asserted", int'(irq_lvl), 1);
    chk("R8 push-pull drives high", int'(irq_oe), 1);
    // R9 battery forces open drain
    on_battery = 1'b1; #1;
    chk("R9 battery releases high", int'(irq_oe), 0);
    wr(2'd0, 8'h0F);
    chk("R9 battery deasserted low driven", int'(irq_oe), 1);
    on_battery = 1'b0;

    // R10 shared pin selector
    wr(2'd3, 8'h1C); // osc, active high, push-pull
    osc_clk = 1'b1; #1;
    chk("R10 osc high", int'(mfo_lvl), 1);
    osc_clk = 1'b0; #1;
    chk("R10 osc low", int'(mfo_lvl), 0);
    wr(2'd3, 8'h20); // timer0, active low, open drain
    tmr0_out = 1'b1; #1;
    chk("R10 timer inverted", int'(mfo_lvl), 0);
    chk("R10 timer od drives", int'(mfo_oe), 1);
    wr(2'd2, 8'h40);
    apply(4'h4, 1'b0, 2'd0, 8'h00);
    wr(2'd3, 8'h34); // code 11 -> interrupt line, active high
    chk("R10 code3 shared irq", int'(mfo_lvl), 1);

    // Random traffic checked against the model
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] e;
      logic [7:0] d;
      logic [1:0] a;
      e = 4'($urandom) & 4'($urandom);
      d = 8'($urandom);
      a = 2'($urandom);
      on_battery = ($urandom % 8) == 0;
      osc_clk = 1'($urandom);
      tmr0_out = 1'($urandom);
      apply(e, 1'($urandom % 3 == 0), a, d);
    end

    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule